// File: doc/BRIEF.md
# Virtual Address Translation Unit

The unit turns one virtual address per cycle into either a physical address or a typed fault. Each request carries a 32-bit virtual address, an address-space identifier, an access kind (fetch, load or store), a misalignment flag, the current privilege (kernel or not) and a mode bit that selects fine-grained 1 KB page numbering. The address space splits into two directly mapped kernel windows, a cached one at 0x8000_0000 to 0x9FFF_FFFF and an uncached one at 0xA000_0000 to 0xBFFF_FFFF, and everything else, which is translated through an external translation buffer.

For translated addresses the unit forms the page number and presents it, with the identifier, on a combinational lookup port. The buffer answers in the same cycle with a hit flag, a per-entry shift amount, an offset mask and an even and an odd half, each half having a frame number, a valid bit and a dirty bit. The unit picks the half, checks it, and builds the physical address. On a buffer-related fault it captures the values a refill handler needs. The result appears one cycle after the request, in a registered response.

Top module: `vat_unit`

## Requirements
- R1: An address whose bits 31..29 are 100 maps directly to `va & 0x1FFF_FFFF`, without using the lookup result; if `req_kernel` is 0 or `req_misaligned` is 1 the response is an address error instead: code 2 for a store (`req_acc` = 2), code 1 for fetch (0) or load (1).
- R2: An address whose bits 31..29 are 101 maps directly to `va & 0x1FFF_FFFF` and never faults, whatever the privilege or alignment.
- R3: A successful response sets `rsp_uncached` exactly when `va & 0xA000_0000` equals `0xA000_0000`; a faulting response has `rsp_uncached` = 0 and `rsp_pa` = 0.
- R4: `lk_vpn` is `va >> 11` (21 bits) with its two low bits forced to 0 unless `req_small_pages` is 1; `lk_asid` equals `req_asid`.
- R5: A misaligned access to a translated address gives an address error (code 2 for stores, code 1 otherwise), whatever the lookup returns.
- R6: An aligned translated access with `lk_hit` = 0 gives a refill fault, code 3.
- R7: On a hit the half is chosen by virtual address bit `lk_shamt`: 0 picks the even half, 1 the odd half; if the chosen half's valid bit is 0 the response is an invalid fault, code 4.
- R8: On success for a translated address, with frame number F of the chosen half and shift amount S (12..31), the physical address is `((F >> (S-12)) << S) | (va & lk_offmask)`, where `lk_offmask` = 2^S - 1.
- R9: For codes 3, 4 and 5 the response carries `rsp_badva` = va, `rsp_vpn2` = `rsp_ctx_vpn2` = page number >> 2, `rsp_vpn2x` = page number bits 1..0 and `rsp_asid` = `req_asid`; for codes 1 and 2 only `rsp_badva` is set and the other captured fields are 0; for code 0 all captured fields are 0.
- R10: A store to a valid half whose dirty bit is 0 gives a modified fault, code 5; fetches and loads to such a half succeed.
- R11: `rsp_valid` rises exactly one cycle after a cycle with `req_valid` = 1 and is 0 otherwise; after reset every response field is 0, and code 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Address-space identifier |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_misaligned | input | 1 | Access is not naturally aligned |
| req_kernel | input | 1 | Requester runs in kernel mode |
| req_small_pages | input | 1 | Keep the two low page-number bits (1 KB pages) |
| lk_vpn | output | 21 | Page number presented to the buffer |
| lk_asid | output | 8 | Identifier presented to the buffer |
| lk_hit | input | 1 | Buffer found a matching entry |
| lk_shamt | input | 5 | Matching entry's shift amount |
| lk_offmask | input | 32 | Matching entry's offset mask |
| lk_pfn_even | input | 20 | Even-half frame number |
| lk_pfn_odd | input | 20 | Odd-half frame number |
| lk_valid_even | input | 1 | Even-half valid bit |
| lk_valid_odd | input | 1 | Odd-half valid bit |
| lk_dirty_even | input | 1 | Even-half dirty bit |
| lk_dirty_odd | input | 1 | Odd-half dirty bit |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 3 | Fault code: 0 none, 1 address error fetch/load, 2 address error store, 3 refill, 4 invalid, 5 modified |
| rsp_pa | output | 32 | Physical address on success |
| rsp_uncached | output | 1 | Uncacheable on success |
| rsp_badva | output | 32 | Captured faulting virtual address |
| rsp_vpn2 | output | 19 | Captured page-pair number |
| rsp_vpn2x | output | 2 | Captured low page-number bits |
| rsp_asid | output | 8 | Captured identifier |
| rsp_ctx_vpn2 | output | 19 | Captured page-pair number for the context register |

## Verification
The bench builds the unit with its default widths: a 32-bit virtual address, an 8-bit identifier, 20-bit frame numbers and a 5-bit shift amount. At these values it walks every combination of the eight top-address segments, the three access kinds, privilege, alignment, page-numbering mode, hit, both valid bits and both dirty bits, under three shift amounts, so every fault priority and both halves are reached with varied address bits. The expected address is computed with the shift formula, not with the mask the design uses.

// File: rtl/vat_pkg.sv
package vat_pkg;

    localparam int VA_W       = 32;
    localparam int ASID_W     = 8;
    localparam int PFN_W      = 20;
    localparam int FRAME_LSB  = 12;
    localparam int SHAMT_W    = 5;
    localparam int PAGE_SHIFT = 11;
    localparam int SEG_W      = 3;
    localparam int PA_W       = PFN_W + FRAME_LSB;
    localparam int PAGE_W     = VA_W - PAGE_SHIFT;
    localparam int PAIR_W     = PAGE_W - 2;

    localparam logic [SEG_W-1:0] SEG_DIRECT_CACHED   = 3'b100;
    localparam logic [SEG_W-1:0] SEG_DIRECT_UNCACHED = 3'b101;
    localparam logic [VA_W-1:0]  UNCACHED_PATTERN    = 32'hA000_0000;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_ADDR_LD = 3'd1,
        FLT_ADDR_ST = 3'd2,
        FLT_MISS    = 3'd3,
        FLT_INVAL   = 3'd4,
        FLT_MOD     = 3'd5
    } fault_e;

    typedef struct packed {
        logic              valid;
        fault_e            fault;
        logic [PA_W-1:0]   pa;
        logic              uncached;
        logic [VA_W-1:0]   badva;
        logic [PAIR_W-1:0] vpn2;
        logic [1:0]        vpn2x;
        logic [ASID_W-1:0] asid;
        logic [PAIR_W-1:0] ctx_vpn2;
    } rsp_t;

endpackage

// File: rtl/vat_seg_decode.sv
module vat_seg_decode
    import vat_pkg::*;
(
    input  logic [VA_W-1:0] va,
    output logic            direct_cached,
    output logic            direct_uncached,
    output logic [PA_W-1:0] direct_pa,
    output logic            uncached_attr
);
    localparam int WIN_W = VA_W - SEG_W;

    logic [SEG_W-1:0] seg;

    always_comb begin
        seg             = va[VA_W-1 -: SEG_W];
        direct_cached   = (seg == SEG_DIRECT_CACHED);
        direct_uncached = (seg == SEG_DIRECT_UNCACHED);
        direct_pa       = '0;
        direct_pa[WIN_W-1:0] = va[WIN_W-1:0];
        uncached_attr   = ((va & UNCACHED_PATTERN) == UNCACHED_PATTERN);
    end
endmodule

// File: rtl/vat_page_form.sv
module vat_page_form
    import vat_pkg::*;
(
    input  logic [PAGE_W-1:0] va_page,
    input  logic              small_pages,
    output logic [PAGE_W-1:0] page,
    output logic [PAIR_W-1:0] pair,
    output logic [1:0]        pair_x
);
    always_comb begin
        page = va_page;
        if (!small_pages) begin
            page[1:0] = 2'b00;
        end
        pair   = page[PAGE_W-1:2];
        pair_x = page[1:0];
    end
endmodule

// File: rtl/vat_frame_sel.sv
module vat_frame_sel
    import vat_pkg::*;
(
    input  logic [VA_W-1:0]    va,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [VA_W-1:0]    offmask,
    input  logic [PFN_W-1:0]   pfn_even,
    input  logic [PFN_W-1:0]   pfn_odd,
    input  logic               valid_even,
    input  logic               valid_odd,
    input  logic               dirty_even,
    input  logic               dirty_odd,
    output logic               half_valid,
    output logic               half_dirty,
    output logic [PA_W-1:0]    frame_pa
);
    logic            odd_half;
    logic [PA_W-1:0] frame_base;

    always_comb begin
        odd_half   = va[shamt];
        half_valid = odd_half ? valid_odd : valid_even;
        half_dirty = odd_half ? dirty_odd : dirty_even;
        frame_base = {(odd_half ? pfn_odd : pfn_even), {FRAME_LSB{1'b0}}};
        frame_pa   = (frame_base & ~offmask) | (va & offmask);
    end
endmodule

// File: rtl/vat_unit.sv
module vat_unit
    import vat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    input  logic [ASID_W-1:0]  req_asid,
    input  logic [1:0]         req_acc,
    input  logic               req_misaligned,
    input  logic               req_kernel,
    input  logic               req_small_pages,
    output logic [PAGE_W-1:0]  lk_vpn,
    output logic [ASID_W-1:0]  lk_asid,
    input  logic               lk_hit,
    input  logic [SHAMT_W-1:0] lk_shamt,
    input  logic [VA_W-1:0]    lk_offmask,
    input  logic [PFN_W-1:0]   lk_pfn_even,
    input  logic [PFN_W-1:0]   lk_pfn_odd,
    input  logic               lk_valid_even,
    input  logic               lk_valid_odd,
    input  logic               lk_dirty_even,
    input  logic               lk_dirty_odd,
    output logic               rsp_valid,
    output logic [2:0]         rsp_fault,
    output logic [PA_W-1:0]    rsp_pa,
    output logic               rsp_uncached,
    output logic [VA_W-1:0]    rsp_badva,
    output logic [PAIR_W-1:0]  rsp_vpn2,
    output logic [1:0]         rsp_vpn2x,
    output logic [ASID_W-1:0]  rsp_asid,
    output logic [PAIR_W-1:0]  rsp_ctx_vpn2
);
    logic              seg_cached_d;
    logic              seg_uncached_d;
    logic [PA_W-1:0]   direct_pa_d;
    logic              uncached_attr_d;
    logic [PAGE_W-1:0] page_d;
    logic [PAIR_W-1:0] pair_d;
    logic [1:0]        pair_x_d;
    logic              half_valid_d;
    logic              half_dirty_d;
    logic [PA_W-1:0]   frame_pa_d;

    rsp_t   rsp_d, rsp_q;
    logic   is_store_d;
    fault_e addr_err_d;
    fault_e tlb_fault_d;

    vat_seg_decode u_seg (
        .va              (req_va),
        .direct_cached   (seg_cached_d),
        .direct_uncached (seg_uncached_d),
        .direct_pa       (direct_pa_d),
        .uncached_attr   (uncached_attr_d)
    );

    vat_page_form u_page (
        .va_page     (req_va[VA_W-1:PAGE_SHIFT]),
        .small_pages (req_small_pages),
        .page        (page_d),
        .pair        (pair_d),
        .pair_x      (pair_x_d)
    );

    vat_frame_sel u_frame (
        .va         (req_va),
        .shamt      (lk_shamt),
        .offmask    (lk_offmask),
        .pfn_even   (lk_pfn_even),
        .pfn_odd    (lk_pfn_odd),
        .valid_even (lk_valid_even),
        .valid_odd  (lk_valid_odd),
        .dirty_even (lk_dirty_even),
        .dirty_odd  (lk_dirty_odd),
        .half_valid (half_valid_d),
        .half_dirty (half_dirty_d),
        .frame_pa   (frame_pa_d)
    );

    assign lk_vpn  = page_d;
    assign lk_asid = req_asid;

    // Next-state computation for the registered response.
    always_comb begin
        rsp_d      = '0;
        is_store_d = (acc_e'(req_acc) == ACC_STORE);
        addr_err_d = is_store_d ? FLT_ADDR_ST : FLT_ADDR_LD;

        // Lookup outcome in priority order: miss, invalid half, clean store.
        if (!lk_hit) begin
            tlb_fault_d = FLT_MISS;
        end else if (!half_valid_d) begin
            tlb_fault_d = FLT_INVAL;
        end else if (is_store_d && !half_dirty_d) begin
            tlb_fault_d = FLT_MOD;
        end else begin
            tlb_fault_d = FLT_NONE;
        end

        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (seg_cached_d) begin
                if (!req_kernel || req_misaligned) begin
                    rsp_d.fault = addr_err_d;
                    rsp_d.badva = req_va;
                end else begin
                    rsp_d.pa       = direct_pa_d;
                    rsp_d.uncached = uncached_attr_d;
                end
            end else if (seg_uncached_d) begin
                rsp_d.pa       = direct_pa_d;
                rsp_d.uncached = uncached_attr_d;
            end else if (req_misaligned) begin
                rsp_d.fault = addr_err_d;
                rsp_d.badva = req_va;
            end else if (tlb_fault_d == FLT_NONE) begin
                rsp_d.pa       = frame_pa_d;
                rsp_d.uncached = uncached_attr_d;
            end else begin
                rsp_d.fault    = tlb_fault_d;
                rsp_d.badva    = req_va;
                rsp_d.vpn2     = pair_d;
                rsp_d.vpn2x    = pair_x_d;
                rsp_d.asid     = req_asid;
                rsp_d.ctx_vpn2 = pair_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_fault    = rsp_q.fault;
    assign rsp_pa       = rsp_q.pa;
    assign rsp_uncached = rsp_q.uncached;
    assign rsp_badva    = rsp_q.badva;
    assign rsp_vpn2     = rsp_q.vpn2;
    assign rsp_vpn2x    = rsp_q.vpn2x;
    assign rsp_asid     = rsp_q.asid;
    assign rsp_ctx_vpn2 = rsp_q.ctx_vpn2;

    // Response timing.
    p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_rsp_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_fault_has_no_pa_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_pa == '0 && !rsp_uncached));

    // Direct windows.
    p_user_in_cached_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_va[31:29] == 3'b100 && !req_kernel)
        |=> (rsp_fault == 3'd1 || rsp_fault == 3'd2));
    p_uncached_window_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_va[31:29] == 3'b101)
        |=> (rsp_fault == 3'd0 && rsp_uncached));

    // Lookup key.
    p_key_low_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_small_pages |-> (lk_vpn[1:0] == 2'b00));

    // Translated path.
    p_misaligned_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_va[31:30] != 2'b10 && req_misaligned)
        |=> (rsp_fault == 3'd1 || rsp_fault == 3'd2));
    p_miss_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_va[31:30] != 2'b10 && !req_misaligned && !lk_hit)
        |=> (rsp_fault == 3'd3));
    p_fetch_never_modified_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_acc != 2'd2) |=> (rsp_fault != 3'd5));
    p_capture_consistent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault >= 3'd3) |-> (rsp_ctx_vpn2 == rsp_vpn2));

endmodule

// File: tb/vat_unit_bench.sv
`timescale 1ns/1ps
module vat_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [7:0]  req_asid = '0;
    logic [1:0]  req_acc = '0;
    logic        req_misaligned = 1'b0;
    logic        req_kernel = 1'b0;
    logic        req_small_pages = 1'b0;
    logic [20:0] lk_vpn;
    logic [7:0]  lk_asid;
    logic        lk_hit = 1'b0;
    logic [4:0]  lk_shamt = 5'd12;
    logic [31:0] lk_offmask = 32'h0000_0FFF;
    logic [19:0] lk_pfn_even = '0;
    logic [19:0] lk_pfn_odd = '0;
    logic        lk_valid_even = 1'b0;
    logic        lk_valid_odd = 1'b0;
    logic        lk_dirty_even = 1'b0;
    logic        lk_dirty_odd = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [31:0] rsp_pa;
    logic        rsp_uncached;
    logic [31:0] rsp_badva;
    logic [18:0] rsp_vpn2;
    logic [1:0]  rsp_vpn2x;
    logic [7:0]  rsp_asid;
    logic [18:0] rsp_ctx_vpn2;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vat_unit u_vat_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_asid(req_asid), .req_acc(req_acc), .req_misaligned(req_misaligned),
        .req_kernel(req_kernel), .req_small_pages(req_small_pages),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_shamt(lk_shamt),
        .lk_offmask(lk_offmask), .lk_pfn_even(lk_pfn_even), .lk_pfn_odd(lk_pfn_odd),
        .lk_valid_even(lk_valid_even), .lk_valid_odd(lk_valid_odd),
        .lk_dirty_even(lk_dirty_even), .lk_dirty_odd(lk_dirty_odd),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .rsp_uncached(rsp_uncached), .rsp_badva(rsp_badva), .rsp_vpn2(rsp_vpn2),
        .rsp_vpn2x(rsp_vpn2x), .rsp_asid(rsp_asid), .rsp_ctx_vpn2(rsp_ctx_vpn2)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            if (fails <= 20)
                $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected response, computed from the requirements.
    logic [2:0]  e_fault;
    logic [31:0] e_pa;
    logic        e_unc;
    logic [31:0] e_badva;
    logic [18:0] e_vpn2;
    logic [1:0]  e_vpn2x;
    logic [7:0]  e_asid;
    logic [20:0] e_key;
    string       e_tag;

    task automatic model();
        logic [2:0]  seg;
        logic [2:0]  aerr;
        logic        odd;
        logic [31:0] pfn;
        int          s;
        seg  = req_va[31:29];
        aerr = (req_acc == 2'd2) ? 3'd2 : 3'd1;
        e_key = req_va[31:11];
        if (!req_small_pages) e_key[1:0] = 2'b00;
        e_fault = 3'd0; e_pa = '0; e_unc = 1'b0; e_badva = '0;
        e_vpn2 = '0; e_vpn2x = '0; e_asid = '0;
        s = int'(lk_shamt);
        odd = req_va[s];
        pfn = {12'd0, odd ? lk_pfn_odd : lk_pfn_even};
        if (seg == 3'b100) begin
            e_tag = "R1";
            if (!req_kernel || req_misaligned) e_fault = aerr;
            else e_pa = req_va & 32'h1FFF_FFFF;
        end else if (seg == 3'b101) begin
            e_tag = "R2";
            e_pa = req_va & 32'h1FFF_FFFF;
        end else if (req_misaligned) begin
            e_tag = "R5";
            e_fault = aerr;
        end else if (!lk_hit) begin
            e_tag = "R6";
            e_fault = 3'd3;
        end else if (!(odd ? lk_valid_odd : lk_valid_even)) begin
            e_tag = "R7";
            e_fault = 3'd4;
        end else if (req_acc == 2'd2 && !(odd ? lk_dirty_odd : lk_dirty_even)) begin
            e_tag = "R10";
            e_fault = 3'd5;
        end else begin
            e_tag = "R8";
            e_pa = ((pfn >> (s - 12)) << s) | (req_va & lk_offmask);
        end
        if (e_fault == 3'd0) begin
            e_unc = ((req_va & 32'hA000_0000) == 32'hA000_0000);
        end else begin
            e_badva = req_va;
            if (e_fault >= 3'd3) begin
                e_vpn2  = e_key[20:2];
                e_vpn2x = e_key[1:0];
                e_asid  = req_asid;
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before the sweep completed");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(rsp_valid == 1'b0, "R11 reset valid", 64'(rsp_valid), 64'd0);
        chk(rsp_fault == 3'd0 && rsp_pa == '0 && rsp_badva == '0, "R11 reset fields",
            64'(rsp_pa), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11 idle after reset", 64'(rsp_valid), 64'd0);

        for (int n = 0; n < 18432; n++) begin
            int          sh, db, vb, hit, sm, mis, kern, acc, seg;
            logic [31:0] h1, h2;
            sh   = n % 3;
            db   = (n / 3) % 4;
            vb   = (n / 12) % 4;
            hit  = (n / 48) % 2;
            sm   = (n / 96) % 2;
            mis  = (n / 192) % 2;
            kern = (n / 384) % 2;
            acc  = (n / 768) % 3;
            seg  = n / 2304;
            h1 = (32'(n) * 32'h9E37_79B1) ^ (32'(n) << 7);
            h2 = (32'(n) * 32'h85EB_CA6B) ^ 32'h5A5A_1234;
            req_valid       = 1'b1;
            req_va          = {3'(seg), h1[28:0]};
            req_asid        = h2[7:0];
            req_acc         = 2'(acc);
            req_misaligned  = 1'(mis);
            req_kernel      = 1'(kern);
            req_small_pages = 1'(sm);
            lk_hit          = 1'(hit);
            lk_shamt        = (sh == 0) ? 5'd12 : (sh == 1) ? 5'd13 : 5'd16;
            lk_offmask      = (32'd1 << lk_shamt) - 32'd1;
            lk_pfn_even     = h2[27:8];
            lk_pfn_odd      = h1[19:0] ^ 20'hC3A5F;
            lk_valid_even   = vb[0];
            lk_valid_odd    = vb[1];
            lk_dirty_even   = db[0];
            lk_dirty_odd    = db[1];
            model();
            #1;
            chk(lk_vpn == e_key, "R4 lookup key", 64'(lk_vpn), 64'(e_key));
            chk(lk_asid == req_asid, "R4 lookup asid", 64'(lk_asid), 64'(req_asid));
            @(negedge clk);
            chk(rsp_valid == 1'b1, "R11 response valid", 64'(rsp_valid), 64'd1);
            chk(rsp_fault == e_fault, {e_tag, " fault code"}, 64'(rsp_fault), 64'(e_fault));
            chk(rsp_pa == e_pa, {e_tag, " physical address R8"}, 64'(rsp_pa), 64'(e_pa));
            chk(rsp_uncached == e_unc, "R3 uncached flag", 64'(rsp_uncached), 64'(e_unc));
            chk(rsp_badva == e_badva, "R9 bad address", 64'(rsp_badva), 64'(e_badva));
            chk(rsp_vpn2 == e_vpn2 && rsp_ctx_vpn2 == e_vpn2, "R9 page pair",
                64'({rsp_vpn2, rsp_ctx_vpn2}), 64'({e_vpn2, e_vpn2}));
            chk(rsp_vpn2x == e_vpn2x && rsp_asid == e_asid, "R9 low bits and asid",
                64'({rsp_vpn2x, rsp_asid}), 64'({e_vpn2x, e_asid}));
        end

        req_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11 no request no response", 64'(rsp_valid), 64'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule